// File: doc/BRIEF.md
# Multi-Mode 8-bit Waveform Timer

This block is an 8-bit up or up/down counter with one compare channel, meant to sit beside a processor inside a larger chip. It advances once for each cycle in which its `tick` input is high; any prescaling happens upstream. A two-bit mode field selects one of four behaviours: a free-running count, clear-on-match, fast PWM, or phase-correct PWM.

Software reaches four registers through a single-cycle write port and a combinational read port. These are the control register, the counter, the compare buffer, and a flag/mask register. The block drives one waveform output together with an enable for it. It also raises two sticky events, compare match and overflow. Each event turns into an interrupt request when its mask bit is set. A flag is cleared either by writing a one to it or by pulsing the matching acknowledge input.

The compare value is double-buffered, and the point at which the active copy is loaded depends on the mode. The waveform action also depends on the mode. A force strobe applies the output action at once, but only in the non-PWM modes. Writing the counter suppresses the match on the following tick.

Top module: `wave_timer8`

## Requirements
- R1: Mode encoding (control bits 1:0): 00 counts up and wraps from 0xFF to 0x00. 11 counts up in the same way. 10 counts up and returns to 0x00 on the tick after the count equals the active compare value. The counter moves only on cycles with `tick` high.
- R2: Mode 01 counts 0 up to 0xFF, then from 0xFF down to 0x00, then up again. The direction reverses on the tick at which the count is 0xFF while rising, or 0x00 while falling. After reset the counter rises.
- R3: A write to the compare address (2) always lands in the buffer, which is what reads back. The active compare value follows the buffer every cycle in modes 00 and 10. In mode 11 it is loaded on the tick that wraps 0xFF to 0x00. In mode 01 it is loaded on the tick where the rising count sits at 0xFF.
- R4: The overflow flag (flag register bit 1) sets on a tick where the count is 0xFF in modes 00, 10 and 11. In mode 01 it sets on the tick where the falling count sits at 0x00.
- R5: In modes 00 and 10 the action field (control bits 5:4) means: 00 leaves the output untouched and disabled, 01 toggles it on a match, 10 drives it low on a match, and 11 drives it high on a match. A match is a tick where the count equals the active compare value.
- R6: In mode 11, action 10 drives the output low on a match and high on the 0xFF to 0x00 wrap. Action 11 does the opposite. Action 01 is reserved and behaves like 00.
- R7: In mode 01, action 10 drives the output low on a match while rising and high on a match while falling. Action 11 is the inverse, and action 01 behaves like 00. Direction means the direction held when the tick arrives.
- R8: In a PWM mode with action bit 5 set, the pin ignores a match when the active compare value is 0xFF. In mode 11 the wrap action still applies. In mode 01 the falling-direction action is applied on the tick at the top turn.
- R9: Writing control with bit 7 set and a non-PWM mode applies the written action to the output in that cycle, in place of any match action. It sets no flag and does not clear the counter. It has no effect when the written mode is PWM. Bit 7 always reads as 0.
- R10: After a counter write (address 1), the next tick produces no match: no flag and no pin action. The write takes priority over a tick in the same cycle.
- R11: The compare flag (bit 0) sets on every match. Each flag is cleared by writing 1 to its bit or by its acknowledge input. A set in the same cycle wins over a clear.
- R12: `cmp_irq` is compare flag AND mask (bit 4), and `ovf_irq` is overflow flag AND mask (bit 5). `wave_oe` is high when the action is non-zero, except for action 01 in a PWM mode. All state resets to zero.
- R13: Read address 0 returns action in bits 5:4 and mode in bits 1:0. Address 1 returns the count, address 2 the compare buffer, and address 3 the masks in bits 5:4 and the flags in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data, combinational |
| cmp_ack | input | 1 | Clears the compare flag |
| ovf_ack | input | 1 | Clears the overflow flag |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | Waveform output enable |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets several corner cases, each with a visible symptom if the design gets it wrong:

- **Compare value of 0xFF in both PWM modes.** A design that skipped the special case would emit a one-tick glitch at the top or at the wrap instead of a steady level.
- **Compare values written in the middle of a PWM period.** Loading them immediately instead of at the mode's update point would shift an edge inside the current period.
- **Turn points of the phase-correct count.** A design that mis-set the direction there would produce the wrong overflow timing and a pin level inverted on matches at 0x00.
- **Counter writes landing exactly on the compare value.** Missing the mask would set the compare flag and act on the pin one tick early.
- **Force strobes issued in PWM modes and together with matches.** A design that honoured them would move the pin where it must stay put.

// File: rtl/wt8_pkg.sv
package wt8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_PCPWM = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_FAST  = 2'b11
  } wmode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CMP   = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  localparam int CTRL_FORCE_BIT = 7;
  localparam int CTRL_ACT_LSB   = 4;
  localparam int CTRL_MODE_LSB  = 0;
  localparam int FLAG_CMP_BIT   = 0;
  localparam int FLAG_OVF_BIT   = 1;
  localparam int MASK_CMP_BIT   = 4;
  localparam int MASK_OVF_BIT   = 5;

  function automatic logic is_pwm(wmode_e m);
    return (m == MODE_PCPWM) || (m == MODE_FAST);
  endfunction

  // pin is driven unless the action is off or reserved (01 in PWM)
  function automatic logic drives_pin(wmode_e m, logic [1:0] a);
    return (a != 2'b00) && !(is_pwm(m) && (a == 2'b01));
  endfunction

  // non-PWM action applied to the present level
  function automatic logic apply_action(logic [1:0] a, logic cur);
    case (a)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wt8_counter.sv
module wt8_counter
  import wt8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wmode_e       mode,
  input  logic [W-1:0] ocr_act,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt_o,
  output logic         dn_o,
  output logic         blk_o,
  output logic         at_max_o,
  output logic         pc_top_o,
  output logic         ovf_evt_o
);

  localparam logic [W-1:0] CNT_MAX    = {W{1'b1}};
  localparam logic [W-1:0] CNT_MAX_M1 = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] CNT_ZERO   = {W{1'b0}};

  logic [W-1:0] cnt_q;
  logic         dn_q;
  logic         blk_q;
  logic [W:0]   nxt;

  // returns {falling, next count}
  function automatic logic [W:0] advance(wmode_e m, logic [W-1:0] c, logic dn,
                                         logic [W-1:0] top);
    case (m)
      MODE_PCPWM: begin
        if (!dn) return (c == CNT_MAX) ? {1'b1, c - 1'b1} : {1'b0, c + 1'b1};
        else     return (c == CNT_ZERO) ? {1'b0, c + 1'b1} : {1'b1, c - 1'b1};
      end
      MODE_CLEAR: return {1'b0, (c == top) ? CNT_ZERO : c + 1'b1};
      default:    return {1'b0, c + 1'b1};
    endcase
  endfunction

  assign nxt = advance(mode, cnt_q, dn_q, ocr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      blk_q <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q <= wr_val;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= nxt[W-1:0];
      dn_q  <= nxt[W];
      blk_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign dn_o      = dn_q;
  assign blk_o     = blk_q;
  assign at_max_o  = tick && (cnt_q == CNT_MAX);
  assign pc_top_o  = tick && (mode == MODE_PCPWM) && !dn_q && (cnt_q == CNT_MAX);
  assign ovf_evt_o = tick && ((mode == MODE_PCPWM) ? (dn_q && cnt_q == CNT_ZERO)
                                                   : (cnt_q == CNT_MAX));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && mode == MODE_FREE && cnt_q == CNT_MAX) |=> (cnt_q == CNT_ZERO));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && mode == MODE_CLEAR && cnt_q == ocr_act) |=> (cnt_q == CNT_ZERO));

  assert_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && mode == MODE_PCPWM && !dn_q && cnt_q == CNT_MAX)
      |=> (dn_q && cnt_q == CNT_MAX_M1));

endmodule

// File: rtl/wt8_compare.sv
module wt8_compare
  import wt8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wmode_e       mode,
  input  logic         wr_ocr,
  input  logic [W-1:0] wr_val,
  input  logic         at_max,
  input  logic         pc_top,
  output logic [W-1:0] ocr_act_o,
  output logic [W-1:0] ocr_buf_o
);

  logic [W-1:0] buf_q, act_q, buf_nxt;
  logic         load;

  assign buf_nxt = wr_ocr ? wr_val : buf_q;
  assign load    = !is_pwm(mode) || ((mode == MODE_FAST) && at_max) || pc_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_nxt;
      if (load) act_q <= buf_nxt;
    end
  end

  assign ocr_act_o = act_q;
  assign ocr_buf_o = buf_q;

  assert_hold_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && !at_max) |=> $stable(ocr_act_o));

endmodule

// File: rtl/wt8_wave.sv
module wt8_wave
  import wt8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wmode_e       mode,
  input  logic [1:0]   act,
  input  logic [W-1:0] cnt,
  input  logic         dn,
  input  logic [W-1:0] ocr,
  input  logic         blk,
  input  logic         at_max,
  input  logic         pc_top,
  input  logic         force_req,
  input  wmode_e       force_mode,
  input  logic [1:0]   force_act,
  output logic         match_evt_o,
  output logic         wave_o,
  output logic         oe_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic wave_q, wave_d, force_evt, ocr_is_top;

  assign match_evt_o = tick && (cnt == ocr) && !blk;
  assign force_evt   = force_req && !is_pwm(force_mode);
  assign ocr_is_top  = (ocr == CNT_MAX);

  always_comb begin
    wave_d = wave_q;
    if (force_evt) begin
      wave_d = apply_action(force_act, wave_q);
    end else if (!is_pwm(mode)) begin
      if (match_evt_o) wave_d = apply_action(act, wave_q);
    end else if (act[1]) begin
      if (mode == MODE_FAST) begin
        if (at_max)                          wave_d = ~act[0];
        else if (match_evt_o && !ocr_is_top) wave_d = act[0];
      end else begin
        if (pc_top && ocr_is_top)            wave_d = ~act[0];
        else if (match_evt_o && !ocr_is_top) wave_d = dn ? ~act[0] : act[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave_o = wave_q;
  assign oe_o   = drives_pin(mode, act);

  assert_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00 && !force_evt) |=> $stable(wave_q));

  assert_fast_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act[1] && ocr_is_top && !at_max && !force_evt) |=> $stable(wave_q));

  assert_force_pwm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && is_pwm(force_mode) && !tick) |=> $stable(wave_q));

endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wt8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic [1:0]   reg_raddr,
  output logic [W-1:0] reg_rdata,
  input  logic         cmp_ack,
  input  logic         ovf_ack,
  output logic         wave_out,
  output logic         wave_oe,
  output logic         cmp_irq,
  output logic         ovf_irq
);

  wmode_e       mode_q;
  logic [1:0]   act_q;
  logic         cmp_flag_q, ovf_flag_q, cmp_mask_q, ovf_mask_q;
  logic         wr_ctrl, wr_cnt, wr_ocr, wr_flags;
  logic [W-1:0] cnt, ocr_act, ocr_buf;
  logic         dn, blk, at_max, pc_top, ovf_evt, match_evt;
  logic         clr_cmp, clr_ovf;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_cnt   = reg_wr && (reg_addr == ADDR_COUNT);
  assign wr_ocr   = reg_wr && (reg_addr == ADDR_CMP);
  assign wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);

  wt8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .ocr_act(ocr_act),
    .wr_cnt(wr_cnt), .wr_val(reg_wdata), .cnt_o(cnt), .dn_o(dn), .blk_o(blk),
    .at_max_o(at_max), .pc_top_o(pc_top), .ovf_evt_o(ovf_evt)
  );

  wt8_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .wr_ocr(wr_ocr), .wr_val(reg_wdata),
    .at_max(at_max), .pc_top(pc_top), .ocr_act_o(ocr_act), .ocr_buf_o(ocr_buf)
  );

  wt8_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .act(act_q), .cnt(cnt),
    .dn(dn), .ocr(ocr_act), .blk(blk), .at_max(at_max), .pc_top(pc_top),
    .force_req(wr_ctrl && reg_wdata[CTRL_FORCE_BIT]),
    .force_mode(wmode_e'(reg_wdata[CTRL_MODE_LSB +: 2])),
    .force_act(reg_wdata[CTRL_ACT_LSB +: 2]),
    .match_evt_o(match_evt), .wave_o(wave_out), .oe_o(wave_oe)
  );

  assign clr_cmp = cmp_ack || (wr_flags && reg_wdata[FLAG_CMP_BIT]);
  assign clr_ovf = ovf_ack || (wr_flags && reg_wdata[FLAG_OVF_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_FREE;
      act_q      <= 2'b00;
      cmp_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
      cmp_mask_q <= 1'b0;
      ovf_mask_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wmode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
        act_q  <= reg_wdata[CTRL_ACT_LSB +: 2];
      end
      if (wr_flags) begin
        cmp_mask_q <= reg_wdata[MASK_CMP_BIT];
        ovf_mask_q <= reg_wdata[MASK_OVF_BIT];
      end
      if (match_evt)    cmp_flag_q <= 1'b1;
      else if (clr_cmp) cmp_flag_q <= 1'b0;
      if (ovf_evt)      ovf_flag_q <= 1'b1;
      else if (clr_ovf) ovf_flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_ACT_LSB +: 2]  = act_q;
        reg_rdata[CTRL_MODE_LSB +: 2] = mode_q;
      end
      ADDR_COUNT: reg_rdata = cnt;
      ADDR_CMP:   reg_rdata = ocr_buf;
      default: begin
        reg_rdata[FLAG_CMP_BIT] = cmp_flag_q;
        reg_rdata[FLAG_OVF_BIT] = ovf_flag_q;
        reg_rdata[MASK_CMP_BIT] = cmp_mask_q;
        reg_rdata[MASK_OVF_BIT] = ovf_mask_q;
      end
    endcase
  end

  assign cmp_irq = cmp_flag_q && cmp_mask_q;
  assign ovf_irq = ovf_flag_q && ovf_mask_q;

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag_q);

  assert_match_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag_q);

  assert_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ack && !match_evt) |=> !cmp_flag_q);

endmodule

// File: tb/wave_timer8_tb_top.sv
module wave_timer8_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [1:0] reg_raddr = 2'd1;
  logic       cmp_ack = 1'b0;
  logic       ovf_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       wave_out, wave_oe, cmp_irq, ovf_irq;

  wave_timer8 #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cmp_ack(cmp_ack), .ovf_ack(ovf_ack), .wave_out(wave_out), .wave_oe(wave_oe),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // reference state
  int m_cnt, m_up, m_blk, m_buf, m_ocr, m_mode, m_act, m_wave, m_fc, m_fo, m_mc, m_mo;
  // per-edge temporaries
  int t_d, t_match, t_ovf, t_top, t_bot, t_nb, t_nw, t_ncnt, t_nup, t_fm;

  function automatic bit pwm(int m);
    return (m == 1) || (m == 3);
  endfunction

  function automatic int apply(int a, int cur);
    if (a == 1) return (cur != 0) ? 0 : 1;
    if (a == 2) return 0;
    if (a == 3) return 1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_blk = 0; m_buf = 0; m_ocr = 0; m_mode = 0;
      m_act = 0; m_wave = 0; m_fc = 0; m_fo = 0; m_mc = 0; m_mo = 0;
    end else begin
      t_d     = int'(reg_wdata);
      t_match = (tick && m_cnt == m_ocr && !m_blk) ? 1 : 0;
      if (m_mode == 1) t_ovf = (tick && m_up == 0 && m_cnt == 0) ? 1 : 0;
      else             t_ovf = (tick && m_cnt == 255) ? 1 : 0;
      t_top = (tick && m_mode == 1 && m_up == 1 && m_cnt == 255) ? 1 : 0;
      t_bot = (tick && m_mode == 3 && m_cnt == 255) ? 1 : 0;
      t_nb  = (reg_wr && reg_addr == 2) ? t_d : m_buf;
      // output pin
      t_nw = m_wave;
      t_fm = t_d % 4;
      if (reg_wr && reg_addr == 0 && t_d >= 128 && !pwm(t_fm)) t_nw = apply((t_d / 16) % 4, m_wave);
      else if (!pwm(m_mode)) begin
        if (t_match != 0) t_nw = apply(m_act, m_wave);
      end else if (m_act >= 2) begin
        if (m_mode == 3) begin
          if (t_bot != 0) t_nw = 1 - (m_act % 2);
          else if (t_match != 0 && m_ocr != 255) t_nw = m_act % 2;
        end else begin
          if (t_top != 0 && m_ocr == 255) t_nw = 1 - (m_act % 2);
          else if (t_match != 0 && m_ocr != 255) t_nw = (m_up != 0) ? (m_act % 2) : 1 - (m_act % 2);
        end
      end
      // counter
      t_ncnt = m_cnt; t_nup = m_up;
      if (tick) begin
        if (m_mode == 1) begin
          if (m_up != 0) begin
            if (m_cnt == 255) begin t_nup = 0; t_ncnt = 254; end else t_ncnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin t_nup = 1; t_ncnt = 1; end else t_ncnt = m_cnt - 1;
          end
        end else begin
          t_nup = 1;
          if (m_mode == 2 && m_cnt == m_ocr) t_ncnt = 0;
          else t_ncnt = (m_cnt + 1) % 256;
        end
      end
      // commit
      if (!pwm(m_mode) || t_top != 0 || t_bot != 0) m_ocr = t_nb;
      m_buf  = t_nb;
      m_wave = t_nw;
      if (reg_wr && reg_addr == 1) begin
        m_cnt = t_d; m_blk = 1;
      end else if (tick) begin
        m_cnt = t_ncnt; m_up = t_nup; m_blk = 0;
      end
      if (t_match != 0) m_fc = 1;
      else if (cmp_ack || (reg_wr && reg_addr == 3 && (t_d % 2) == 1)) m_fc = 0;
      if (t_ovf != 0) m_fo = 1;
      else if (ovf_ack || (reg_wr && reg_addr == 3 && ((t_d / 2) % 2) == 1)) m_fo = 0;
      if (reg_wr && reg_addr == 3) begin m_mc = (t_d / 16) % 2; m_mo = (t_d / 32) % 2; end
      if (reg_wr && reg_addr == 0) begin m_mode = t_fm; m_act = (t_d / 16) % 4; end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic check_all();
    int exp_rd;
    if (!rst_n) return;
    chk("R5,R6,R7,R8,R9", "wave_out", int'(wave_out), m_wave);
    chk("R12", "wave_oe", int'(wave_oe), (m_act != 0 && !(pwm(m_mode) && m_act == 1)) ? 1 : 0);
    chk("R10,R11,R12", "cmp_irq", int'(cmp_irq), m_fc * m_mc);
    chk("R4,R11,R12", "ovf_irq", int'(ovf_irq), m_fo * m_mo);
    case (reg_raddr)
      2'd0:    exp_rd = m_act * 16 + m_mode;
      2'd1:    exp_rd = m_cnt;
      2'd2:    exp_rd = m_buf;
      default: exp_rd = m_mo * 32 + m_mc * 16 + m_fo * 2 + m_fc;
    endcase
    if (reg_raddr == 2'd1) chk("R1,R2,R10", "count", int'(reg_rdata), exp_rd);
    else chk("R3,R4,R9,R11,R13", "read data", int'(reg_rdata), exp_rd);
  endtask

  task automatic step(input bit t, input bit w, input int a, input int d,
                      input bit ac, input bit ao);
    @(negedge clk);
    check_all();
    cyc++;
    tick      = t;
    reg_wr    = w;
    reg_addr  = 2'(a);
    reg_wdata = 8'(d);
    cmp_ack   = ac;
    ovf_ack   = ao;
    reg_raddr = ((cyc % 3) == 0) ? 2'($urandom % 4) : 2'd1;
  endtask

  task automatic wr(input int a, input int d);
    step(1'b0, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic run(input int n, input int tick_pct, input int wr_pct, input bit [3:0] amask);
    for (int i = 0; i < n; i++) begin
      bit t, w;
      int a;
      t = ($urandom % 100) < tick_pct;
      w = ($urandom % 100) < wr_pct;
      a = $urandom % 4;
      while (!amask[a]) a = $urandom % 4;
      step(t, w, a, $urandom % 256, ($urandom % 40) == 0, ($urandom % 40) == 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);               // reset state, R12 and R13
    step(0, 0, 0, 0, 0, 0);
    // R1 R5: free-running, toggle on match
    wr(0, 8'h10); wr(2, 8'h40); wr(3, 8'h30);
    run(700, 100, 2, 4'b1100);
    // R9: force in non-PWM mode, with and without ticks
    wr(0, 8'h90); wr(0, 8'hA0); wr(0, 8'hB2);
    step(1, 1, 0, 8'h90, 0, 0);
    // R1 R5: clear-on-match, set on match
    wr(0, 8'h32); wr(2, 8'h20);
    run(400, 80, 1, 4'b1100);
    wr(0, 8'h22); run(300, 100, 0, 4'b1000);
    // R6 R3: fast PWM, non-inverting and inverting, mid-period compare writes
    wr(0, 8'h23); wr(2, 8'h80); run(600, 100, 1, 4'b0100);
    wr(2, 8'hFF); run(600, 100, 0, 4'b1000);   // R8
    wr(2, 8'h00); run(600, 100, 0, 4'b1000);
    wr(0, 8'h33); wr(2, 8'h80); run(600, 100, 1, 4'b0100);
    wr(2, 8'hFF); run(600, 100, 0, 4'b1000);   // R8 inverting
    wr(0, 8'h13); run(300, 100, 0, 4'b1000);   // reserved action
    wr(0, 8'hA3); step(0, 0, 0, 0, 0, 0);      // R9 force ignored in PWM
    wr(0, 8'hB3); step(0, 0, 0, 0, 0, 0);
    // R2 R7: phase-correct PWM
    wr(0, 8'h21); wr(2, 8'h80); run(1200, 100, 1, 4'b0100);
    wr(2, 8'hFF); run(1200, 100, 0, 4'b1000);  // R8 at top turn
    wr(0, 8'h31); wr(2, 8'h10); run(1200, 100, 0, 4'b1000);
    wr(2, 8'h00); run(1200, 100, 0, 4'b1000);
    wr(1, 8'hF0); run(600, 70, 2, 4'b1110);
    // R10: counter write onto the compare value masks the next match
    wr(0, 8'h10); wr(2, 8'h50); wr(3, 8'h31);
    step(0, 1, 1, 8'h50, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 8'h4F, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    run(300, 100, 0, 4'b1000);
    // R11: acknowledge and write-one clear
    step(0, 0, 0, 0, 1, 1);
    wr(3, 8'h33);
    // mixed stimulus across all registers and modes
    run(6000, 60, 8, 4'b1111);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule